// File: doc/BRIEF.md
# Timer Channel Count Latch and Status Read-Back

This block is the host-facing read path of one down-counting timer channel. The host reads the 16-bit count through an 8-bit data path. A counter-latch command, or a read-back command with its count request set, takes a snapshot of the running count. The next byte reads are served from that snapshot while the counter keeps running, so both halves of a two-byte read belong to the same value. The snapshot is dropped once every byte the access mode calls for has been read, or when the channel is reprogrammed.

A read-back command can also capture a status byte. The status byte holds the OUT level, the null-count flag and the low six bits of the channel's control word. A captured status byte is returned ahead of any count bytes. When nothing is latched, reads return the live count through the same byte order. The counting logic sits outside this block and supplies the live count, OUT, null-count and control bits.

Top module: `tmr_readback`

## Requirements
- R1: A count latch (`cnt_latch`, or `rb_cmd` with `rb_cnt`=1) captures `live_cnt`. Later reads return bytes of that captured value even when `live_cnt` changes.
- R2: The captured count is held until all bytes of the access mode have been read. One read releases it in the single-byte modes and two reads release it in LSB-then-MSB mode. After that, reads return the live count.
- R3: A count latch issued while a captured count is still held is ignored. The first captured value is kept.
- R4: A read-back with `rb_sts`=1 captures a status byte. Bit 7 is `out_lvl`, bit 6 is `null_cnt` (1 = newly written count not yet loaded) and bits 5..0 are `ctrl_bits[5:0]`, all taken at the command.
- R5: When a status byte and a count are both held, the first read returns the status byte. The reads after it return the count bytes.
- R6: `acc_mode` 2'b01 returns only the low byte and 2'b10 only the high byte. 2'b11 and 2'b00 alternate low then high through a byte pointer that starts at low.
- R7: A pulse on `cw_wr` (control word written) drops any held count and status and resets the byte pointer to low.
- R8: A status read-back issued between the low and high byte reads of a count is returned next. The count sequence then resumes with the high byte of the same held value.
- R9: With nothing latched, reads return `live_cnt` using the same byte selection and pointer as R6.
- R10: After reset nothing is held, the pointer is at low, and `rd_data` shows the live low byte in LSB-then-MSB mode.
- R11: A second status capture while a status byte is still held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_cnt | input | 16 | Running count from the counting logic |
| out_lvl | input | 1 | Current OUT level of the channel |
| null_cnt | input | 1 | New count written but not yet loaded |
| ctrl_bits | input | 6 | Low six bits of the last control word |
| acc_mode | input | 2 | Byte access mode (see R6) |
| cw_wr | input | 1 | Control word written to this channel |
| cnt_latch | input | 1 | Counter-latch command |
| rb_cmd | input | 1 | Read-back command strobe |
| rb_cnt | input | 1 | Read-back requests a count latch |
| rb_sts | input | 1 | Read-back requests a status latch |
| rd | input | 1 | Host read strobe; consumes the byte on rd_data |
| rd_data | output | 8 | Byte currently presented to the host |

## Verification
A table of count values is latched in each access mode, and the live count is changed to its complement before the bytes are read. A wrong byte then shows whether the snapshot is missing (live bytes appear) or the byte selection is wrong (the halves are swapped). Directed cases cover these orderings:
- status and count latched together;
- status inserted between the two count bytes;
- repeated latch commands of either kind;
- reprogramming in the middle of a read.

Each ordering separates a wrong priority from a lost pointer or a latch that is released early.

// File: rtl/tmr_readback.sv
module tmr_readback #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] live_cnt,
  input  logic             out_lvl,
  input  logic             null_cnt,
  input  logic [5:0]       ctrl_bits,
  input  logic [1:0]       acc_mode,
  input  logic             cw_wr,
  input  logic             cnt_latch,
  input  logic             rb_cmd,
  input  logic             rb_cnt,
  input  logic             rb_sts,
  input  logic             rd,
  output logic [7:0]       rd_data
);
  localparam int HB = CNT_W / 2;

  logic             cnt_held, sts_held, rd_ptr;
  logic [CNT_W-1:0] snap;
  logic [7:0]       sts_snap;

  wire              two_byte = (acc_mode == 2'b11) || (acc_mode == 2'b00);
  wire              take_hi  = (acc_mode == 2'b10) || (two_byte && rd_ptr);
  wire              last_rd  = !two_byte || rd_ptr;
  wire [CNT_W-1:0]  src      = cnt_held ? snap : live_cnt;
  wire              do_cl    = cnt_latch || (rb_cmd && rb_cnt);
  wire              do_sl    = rb_cmd && rb_sts;

  assign rd_data = sts_held ? sts_snap : (take_hi ? src[CNT_W-1:HB] : src[HB-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n || cw_wr) begin
      cnt_held <= 1'b0;
      sts_held <= 1'b0;
      rd_ptr   <= 1'b0;
      snap     <= '0;
      sts_snap <= '0;
    end else begin
      if (rd) begin
        if (sts_held) sts_held <= 1'b0;
        else begin
          if (two_byte) rd_ptr <= !rd_ptr;
          if (last_rd) cnt_held <= 1'b0;
        end
      end
      if (do_cl && !cnt_held) begin
        cnt_held <= 1'b1;
        snap     <= live_cnt;
      end
      if (do_sl && !sts_held) begin
        sts_held <= 1'b1;
        sts_snap <= {out_lvl, null_cnt, ctrl_bits};
      end
    end
  end
endmodule

// File: rtl/tmr_readback_chk.sv
module tmr_readback_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_lvl,
  input logic       null_cnt,
  input logic [5:0] ctrl_bits,
  input logic [1:0] acc_mode,
  input logic       cw_wr,
  input logic       cnt_latch,
  input logic       rb_cmd,
  input logic       rb_cnt,
  input logic       rb_sts,
  input logic       rd,
  input logic [7:0] rd_data,
  input logic       cnt_held,
  input logic       sts_held,
  input logic       rd_ptr
);
  a_r1_snapshot_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_held && !sts_held && !rd && !cw_wr && !rb_cmd) |=>
      (!$stable(acc_mode) || $stable(rd_data)));

  a_r4_status_format: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_cmd && rb_sts && !sts_held && !cw_wr) |=>
      (rd_data == {$past(out_lvl), $past(null_cnt), $past(ctrl_bits)}));

  a_r2_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && cnt_held && !sts_held && !cw_wr && !cnt_latch && !rb_cmd &&
     (acc_mode == 2'b01 || acc_mode == 2'b10)) |=> !cnt_held);

  a_r7_reprogram: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr |=> (!cnt_held && !sts_held && !rd_ptr));

  a_r6_ptr_moves_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !cw_wr) |=> $stable(rd_ptr));

  a_r3_second_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_held && !rd && !cw_wr) |=> cnt_held);
endmodule

bind tmr_readback tmr_readback_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_lvl(out_lvl), .null_cnt(null_cnt),
  .ctrl_bits(ctrl_bits), .acc_mode(acc_mode), .cw_wr(cw_wr),
  .cnt_latch(cnt_latch), .rb_cmd(rb_cmd), .rb_cnt(rb_cnt), .rb_sts(rb_sts),
  .rd(rd), .rd_data(rd_data), .cnt_held(cnt_held), .sts_held(sts_held),
  .rd_ptr(rd_ptr)
);

// File: tb/tb_tmr_readback.sv
module tb_tmr_readback;
  logic clk = 0, rst_n = 0;
  logic [15:0] live_cnt = 16'h0;
  logic out_lvl = 0, null_cnt = 0, cw_wr = 0, cnt_latch = 0;
  logic rb_cmd = 0, rb_cnt = 0, rb_sts = 0, rd = 0;
  logic [5:0] ctrl_bits = 0;
  logic [1:0] acc_mode = 2'b11;
  logic [7:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_readback dut (.clk(clk), .rst_n(rst_n), .live_cnt(live_cnt), .out_lvl(out_lvl),
    .null_cnt(null_cnt), .ctrl_bits(ctrl_bits), .acc_mode(acc_mode), .cw_wr(cw_wr),
    .cnt_latch(cnt_latch), .rb_cmd(rb_cmd), .rb_cnt(rb_cnt), .rb_sts(rb_sts),
    .rd(rd), .rd_data(rd_data));

  // {mode, count, first byte, second byte, live byte after release}
  localparam logic [41:0] VEC [6] = '{
    {2'b11, 16'h1234, 8'h34, 8'h12, 8'hCB},
    {2'b01, 16'hABCD, 8'hCD, 8'h00, 8'h32},
    {2'b10, 16'hABCD, 8'hAB, 8'h00, 8'h54},
    {2'b11, 16'h00FF, 8'hFF, 8'h00, 8'h00},
    {2'b11, 16'hFF00, 8'h00, 8'hFF, 8'hFF},
    {2'b10, 16'h8001, 8'h80, 8'h00, 8'h7F}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  task automatic readback(input logic c, input logic s);
    @(negedge clk) begin rb_cmd = 1; rb_cnt = c; rb_sts = s; end
    @(negedge clk) begin rb_cmd = 0; rb_cnt = 0; rb_sts = 0; end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    live_cnt = 16'h5AA5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset live low", rd_data, 8'hA5);

    foreach (VEC[i]) begin
      acc_mode = VEC[i][41:40];
      live_cnt = VEC[i][39:24];
      pulse(cnt_latch);
      live_cnt = ~VEC[i][39:24];
      @(negedge clk);
      chk("R1 R6 first byte", rd_data, VEC[i][23:16]);
      pulse(rd);
      if (acc_mode == 2'b11) begin
        chk("R1 R6 second byte", rd_data, VEC[i][15:8]);
        pulse(rd);
      end
      chk("R2 released to live", rd_data, VEC[i][7:0]);
    end

    acc_mode = 2'b11;
    live_cnt = 16'h1111; pulse(cnt_latch);
    live_cnt = 16'h2222; pulse(cnt_latch);
    chk("R3 second latch ignored lo", rd_data, 8'h11);
    pulse(rd);
    chk("R3 second latch ignored hi", rd_data, 8'h11);
    pulse(rd);

    live_cnt = 16'h4321; out_lvl = 1; null_cnt = 0; ctrl_bits = 6'h2D;
    readback(1, 1);
    live_cnt = 16'h9999; out_lvl = 0; ctrl_bits = 6'h00;
    chk("R4 R5 status first", rd_data, 8'hAD);
    pulse(rd);
    chk("R5 count lo after status", rd_data, 8'h21);
    pulse(rd);
    chk("R5 count hi after status", rd_data, 8'h43);
    pulse(rd);

    out_lvl = 0; null_cnt = 1; ctrl_bits = 6'h15;
    readback(0, 1);
    chk("R4 status null flag", rd_data, 8'h55);
    out_lvl = 1; null_cnt = 0; ctrl_bits = 6'h3F;
    readback(0, 1);
    chk("R11 second status ignored", rd_data, 8'h55);
    pulse(rd);
    chk("R4 status consumed live lo", rd_data, 8'h99);

    live_cnt = 16'h3344; pulse(cnt_latch);
    live_cnt = 16'hAABB;
    pulse(rd);
    chk("R7 before reprogram hi", rd_data, 8'h33);
    pulse(cw_wr);
    chk("R7 reprogram drops latch", rd_data, 8'hBB);

    live_cnt = 16'h7788; pulse(cnt_latch);
    live_cnt = 16'h0000;
    pulse(rd);
    out_lvl = 1; null_cnt = 1; ctrl_bits = 6'h01;
    readback(0, 1);
    chk("R8 inserted status", rd_data, 8'hC1);
    pulse(rd);
    chk("R8 resume hi byte", rd_data, 8'h77);
    pulse(rd);

    live_cnt = 16'hBEEF;
    @(negedge clk);
    chk("R9 live lo", rd_data, 8'hEF);
    pulse(rd);
    live_cnt = 16'hCAFE;
    @(negedge clk);
    chk("R9 live hi follows", rd_data, 8'hCA);
    pulse(rd);
    acc_mode = 2'b10;
    @(negedge clk);
    chk("R6 R9 msb only live", rd_data, 8'hCA);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule